// File: doc/BRIEF.md
# Subcode Serial Output Port

This block takes the eight subcode bits of each frame, P through W, and presents them one at a time on a single serial data pin. An external device reads them with its own read clock. The block captures the byte at the rising edge of the frame clock. Each falling edge of the read clock then moves the next bit onto the pin. Frames that carry a subcode sync pattern get an extra leading flag slot ahead of the data. The flag is high for the first sync pattern (S0) and low for the second (S1).

The frame clock and the read clock come from outside the block's clock domain. Each is brought in through a synchronizer chain and then edge-detected on the system clock. The per-frame inputs are the subcode byte and the two sync-detect flags. An S1 detection counts only when the frame just before it was an S0 frame. Otherwise the frame is sent as ordinary data. Once all defined slots have been read out, any further read clock edges shift out zeros until the next frame is captured.

Top module: `subcode_serial_port`

## Requirements
- R1: After reset the serial output is low, and read clock edges arriving before the first frame capture keep it low.
- R2: The subcode byte and the sync-detect flags are captured on a rising edge of the frame clock. The first slot of that frame appears on the serial output without any read clock edge.
- R3: A frame captured with the S0 flag set starts with a flag slot driven high. Its slots after that follow the R6 order.
- R4: A frame captured with S1 set and S0 clear, whose previous captured frame had S0 set, starts with a flag slot driven low. Its slots after that follow the R6 order.
- R5: A frame captured with S1 set and S0 clear, whose previous captured frame did not have S0 set, is sent as a normal frame with no flag slot.
- R6: A normal frame outputs sub_byte bit 7 (P) first, then bit 6 (Q), then bits 5 down to 0 (R through W). One further bit is output on each read clock falling edge.
- R7: The serial output changes only on a read clock falling edge or a frame capture. A read clock rising edge and a frame clock falling edge have no effect on it.
- R8: Once the last defined slot of a frame has been shifted out, each further read clock falling edge outputs a zero until the next capture.
- R9: When S0 and S1 are both set at capture, the frame is treated as an S0 frame (flag slot high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clk_i | input | 1 | Frame clock; the byte is captured on its rising edge |
| read_clk_i | input | 1 | External read clock; bits advance on its falling edge |
| sub_byte_i | input | 8 | Subcode byte: bit 7 = P, bit 6 = Q, bits 5..0 = R..W |
| s0_det_i | input | 1 | S0 sync pattern detected in this frame |
| s1_det_i | input | 1 | S1 sync pattern detected in this frame |
| sub_sd_o | output | 1 | Serial subcode data |

## Verification
The assertions assume that the subcode byte and both detect flags are stable from a few system clocks before each frame clock rising edge until several clocks after it. The synchronized edge reaches the capture logic only after the synchronizer latency. The assertions also assume that each level of the frame clock and the read clock lasts several system clocks, so that no edge is lost in synchronization. The stimulus changes the byte and flags only while the frame clock is low and long before its next rise. It holds every clock level for eight system clocks.

// File: rtl/subout_pkg.sv
package subout_pkg;

  // Kind of frame decided at capture time
  typedef enum logic [1:0] {
    FRM_NORMAL = 2'd0,
    FRM_SYNC0  = 2'd1,
    FRM_SYNC1  = 2'd2
  } frm_kind_e;

  localparam int unsigned SUB_BITS = 8;

endpackage

// File: rtl/subout_edge.sv
module subout_edge #(
  parameter int unsigned STAGES      = 2,
  parameter bit          DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;
  logic              hist_q;
  logic              hist_n;
  logic              lvl;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], async_i};
    hist_n = lvl;
  end

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      hist_q <= hist_n;
    end
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign edge_o = lvl & ~hist_q;
    end else begin : g_fall
      assign edge_o = ~lvl & hist_q;
    end
  endgenerate

  // R7
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);

endmodule

// File: rtl/subout_qual.sv
module subout_qual
  import subout_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_ld_i,
  input  logic      s0_i,
  input  logic      s1_i,
  output frm_kind_e kind_o
);

  logic prev_s0_q;
  logic prev_s0_n;
  logic prev_en;

  assign prev_en = frame_ld_i;

  always_comb begin
    prev_s0_n = prev_s0_q;
    if (prev_en) prev_s0_n = s0_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s0_q <= 1'b0;
    else        prev_s0_q <= prev_s0_n;
  end

  always_comb begin
    if (s0_i)                   kind_o = FRM_SYNC0;
    else if (s1_i && prev_s0_q) kind_o = FRM_SYNC1;
    else                        kind_o = FRM_NORMAL;
  end

endmodule

// File: rtl/subout_shift.sv
module subout_shift
  import subout_pkg::*;
#(
  parameter int unsigned SUB_W = SUB_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  frm_kind_e        kind_i,
  input  logic [SUB_W-1:0] byte_i,
  output logic             sd_o
);

  localparam int unsigned SR_W  = SUB_W + 1;
  localparam int unsigned CNT_W = $clog2(SUB_W + 2);

  logic [SR_W-1:0]  sr_q, sr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    if (load_i) begin
      unique case (kind_i)
        FRM_SYNC0: begin
          sr_n  = {1'b1, byte_i};
          cnt_n = CNT_W'(SR_W);
        end
        FRM_SYNC1: begin
          sr_n  = {1'b0, byte_i};
          cnt_n = CNT_W'(SR_W);
        end
        default: begin
          sr_n  = {byte_i, 1'b0};
          cnt_n = CNT_W'(SUB_W);
        end
      endcase
    end else if (shift_i) begin
      sr_n  = {sr_q[SR_W-2:0], 1'b0};
      cnt_n = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
    end
  end

  assign sd_o = sr_q[SR_W-1];

  // R8
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (sr_q == '0));

  // R6
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (sd_o == $past(sr_q[SR_W-2])));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_i && !load_i) |=> $stable(sd_o));

endmodule

// File: rtl/subcode_serial_port.sv
module subcode_serial_port
  import subout_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SUB_W       = SUB_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clk_i,
  input  logic             read_clk_i,
  input  logic [SUB_W-1:0] sub_byte_i,
  input  logic             s0_det_i,
  input  logic             s1_det_i,
  output logic             sub_sd_o
);

  localparam int unsigned N_CLK = 2;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // Index 0: frame clock rising edge, index 1: read clock falling edge
  logic [N_CLK-1:0] clk_in;
  logic [N_CLK-1:0] clk_evt;

  assign clk_in = {read_clk_i, frame_clk_i};

  generate
    for (genvar g = 0; g < N_CLK; g++) begin : g_edge
      subout_edge #(
        .STAGES     (SYNC_STAGES),
        .DETECT_RISE(g == 0)
      ) u_edge (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .async_i(clk_in[g]),
        .edge_o (clk_evt[g])
      );
    end
  endgenerate

  logic      frame_ld;
  logic      bit_shift;
  frm_kind_e kind;

  assign frame_ld  = clk_evt[0];
  assign bit_shift = clk_evt[1];

  subout_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .frame_ld_i(frame_ld),
    .s0_i      (s0_det_i),
    .s1_i      (s1_det_i),
    .kind_o    (kind)
  );

  subout_shift #(.SUB_W(SUB_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (frame_ld),
    .shift_i(bit_shift),
    .kind_i (kind),
    .byte_i (sub_byte_i),
    .sd_o   (sub_sd_o)
  );

  // R3
  s0_flag_high_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_ld && s0_det_i) |=> sub_sd_o);

  // R4
  s1_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_ld && kind == FRM_SYNC1) |=> !sub_sd_o);

  // R6
  normal_first_p_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_ld && kind == FRM_NORMAL) |=> (sub_sd_o == $past(sub_byte_i[SUB_W-1])));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    (!rst_int_n) |=> !sub_sd_o);

endmodule

// File: tb/sim_subcode_serial_port.sv
module sim_subcode_serial_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_clk = 1'b0;
  logic       read_clk = 1'b0;
  logic [7:0] sub_byte = 8'h00;
  logic       s0_det = 1'b0;
  logic       s1_det = 1'b0;
  logic       sd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  subcode_serial_port u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_clk_i(frame_clk),
    .read_clk_i (read_clk),
    .sub_byte_i (sub_byte),
    .s0_det_i   (s0_det),
    .s1_det_i   (s1_det),
    .sub_sd_o   (sd)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sub_sd_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: capture, then 11 read pulses. Slot list built from the requirements.
  task automatic run_frame(input logic [7:0] b, input logic f_s0, input logic f_s1,
                           input logic is_sync, input logic flag, input string req);
    logic [11:0] exp_slots;
    if (is_sync) exp_slots = {flag, b, 3'b000};
    else         exp_slots = {b, 4'b0000};
    sub_byte = b;
    s0_det   = f_s0;
    s1_det   = f_s1;
    wait_clk(4);
    frame_clk = 1'b1;
    wait_clk(8);
    check({req, "/R2 first slot"}, sd, exp_slots[11]);
    frame_clk = 1'b0;
    wait_clk(8);
    check("R7 frame fall", sd, exp_slots[11]);
    for (int i = 1; i < 12; i++) begin
      read_clk = 1'b1;
      wait_clk(8);
      check("R7 read rise", sd, exp_slots[12 - i]);
      read_clk = 1'b0;
      wait_clk(8);
      if ((is_sync && i >= 9) || (!is_sync && i >= 8))
        check("R8 tail zero", sd, exp_slots[11 - i]);
      else
        check(req, sd, exp_slots[11 - i]);
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 reset", sd, 1'b0);
    for (int i = 0; i < 3; i++) begin
      read_clk = 1'b1;
      wait_clk(8);
      read_clk = 1'b0;
      wait_clk(8);
      check("R1 no frame", sd, 1'b0);
    end

    // R5: S1 right after reset has no S0 predecessor
    run_frame(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, "R5");

    // R6: every byte as a normal frame
    for (int v = 0; v < 256; v++)
      run_frame(8'(v), 1'b0, 1'b0, 1'b0, 1'b0, "R6");

    // R3 then R4: S0 followed by a qualified S1
    run_frame(8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    run_frame(8'hC3, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    // R5: S1 after an S1 frame is not qualified
    run_frame(8'h81, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    // R9: both flags set counts as S0, and qualifies the next S1
    run_frame(8'h5A, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
    run_frame(8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    run_frame(8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    run_frame(8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    // R5: normal frame between S0 and S1 breaks qualification
    run_frame(8'h01, 1'b0, 1'b1, 1'b0, 1'b0, "R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule